// File: doc/BRIEF.md
# Multi-Pool Rename Credit Tracker

This block keeps a running count of the physical rename entries in use across several register pools. Pool 0 is a global pool that takes in every architectural register, so it is charged for every definition. The pools numbered from 1 up each own a subset of registers. Every definition carries the index of its owning pool and a cost, which is the number of physical entries that one definition takes. A register that belongs only to the global pool normally has cost 1.

Dispatch logic presents up to `LANES` destination registers per cycle on a query port. The block answers in the same cycle with a stall mask that has one bit per pool. An all-zero mask means the group may dispatch. A separate fatal output reports a group that can never fit, because it asks a bounded pool for more entries than the pool holds in total. Allocate and free strobes then move the counters. Each strobe carries one register's pool index and cost, plus a flag for writes that take no entries. A pool whose capacity parameter is zero has no bound.

Top module: `rcred_tracker`

## Requirements
- R1: After reset every used count reads 0, `underflow_err` is low and the stall mask is all zero.
- R2: An allocate with `alloc_nocharge` low adds `alloc_cost` to pool 0. When `alloc_pool` is nonzero it also adds the cost to that pool. With `alloc_pool` = 0, only pool 0 changes. The count is visible on `used_count` (pool p at bits p*CNT_W upward) one cycle later.
- R3: A free with `free_nocharge` low subtracts `free_cost` from pool 0. When `free_pool` is nonzero it also subtracts the cost from that pool.
- R4: An allocate or free with its nocharge flag set leaves every used count unchanged.
- R5: An allocate and a free in the same cycle both apply, so each pool moves by the net difference.
- R6: For each pool, the query demand is the sum of the costs of the valid lanes whose pool index names that pool. Pool 0 sums every valid lane. Lanes with `q_valid` low add nothing.
- R7: Bit p of `stall_mask` is 1 when the pool's demand is nonzero, its capacity is nonzero, and used plus demand exceeds the capacity. Otherwise the bit is 0. The mask is combinational within the cycle.
- R8: A pool whose capacity is 0 never raises its stall bit, whatever its demand and count.
- R9: `never_fit` is 1 when some bounded pool has a nonzero demand larger than its capacity.
- R10: A used count that would exceed 2^CNT_W-1 holds at 2^CNT_W-1.
- R11: A free that would take a count below zero sets that count to 0. It also raises `underflow_err` from the next cycle, and the flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | LANES | Per-lane query valid |
| q_pool | input | LANES*PW | Per-lane pool index, lane l at bits l*PW |
| q_cost | input | LANES*COST_W | Per-lane cost, lane l at bits l*COST_W |
| alloc_en | input | 1 | Allocate strobe |
| alloc_pool | input | PW | Pool index of the allocated register |
| alloc_cost | input | COST_W | Entries the allocation takes |
| alloc_nocharge | input | 1 | Allocation takes no entries |
| free_en | input | 1 | Free strobe |
| free_pool | input | PW | Pool index of the freed register |
| free_cost | input | COST_W | Entries returned |
| free_nocharge | input | 1 | Free returns no entries |
| stall_mask | output | NUM_POOLS | Per-pool not-enough-entries bits |
| never_fit | output | 1 | Query can never fit a bounded pool |
| used_count | output | NUM_POOLS*CNT_W | Used count of each pool |
| underflow_err | output | 1 | Sticky underflow flag |

## Verification
On every cycle, the assertions check three things. A balanced or empty update leaves a counter unchanged. An underflow always leaves the counter at zero and the flag never drops. A fatal query always shows at least one stall bit. Only the bench scenarios, compared against the reference model, can show the rest: that costs reach the right pools, that invalid lanes and unbounded pools are ignored, and the exact stall threshold and saturation point. The bench also drives random traffic that mixes simultaneous allocates and frees.

// File: rtl/rcred_pkg.sv
package rcred_pkg;
  // True when a register owned by pool `owner` charges counter `pool`.
  function automatic logic pool_hit(input int owner, input int pool);
    return (pool == 0) || (owner == pool);
  endfunction
endpackage

// File: rtl/rcred_demand.sv
module rcred_demand #(
  parameter int LANES     = 4,
  parameter int NUM_POOLS = 4,
  parameter int PW        = 2,
  parameter int COST_W    = 3,
  parameter int REQ_W     = 6
) (
  input  logic [LANES-1:0]           q_valid,
  input  logic [LANES*PW-1:0]        q_pool,
  input  logic [LANES*COST_W-1:0]    q_cost,
  output logic [NUM_POOLS*REQ_W-1:0] req
);
  import rcred_pkg::*;

  for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
    logic [REQ_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int l = 0; l < LANES; l++) begin
        if (q_valid[l] && pool_hit(int'(q_pool[l*PW +: PW]), p))
          acc = acc + REQ_W'(q_cost[l*COST_W +: COST_W]);
      end
    end
    assign req[p*REQ_W +: REQ_W] = acc;
  end
endmodule

// File: rtl/rcred_pool_ctr.sv
module rcred_pool_ctr #(
  parameter int CNT_W   = 8,
  parameter int COST_W  = 3,
  parameter int PW      = 2,
  parameter int POOL_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [PW-1:0]     alloc_pool,
  input  logic [COST_W-1:0] alloc_cost,
  input  logic              alloc_nocharge,
  input  logic              free_en,
  input  logic [PW-1:0]     free_pool,
  input  logic [COST_W-1:0] free_cost,
  input  logic              free_nocharge,
  output logic [CNT_W-1:0]  used,
  output logic              uf_hit
);
  import rcred_pkg::*;

  localparam int W = CNT_W + 2;
  localparam logic [W-1:0] MAX_CNT = W'({CNT_W{1'b1}});

  logic [CNT_W-1:0] used_q, used_d;
  logic [W-1:0]     inc_amt, dec_amt, grow, diff;
  logic             upd_en;

  always_comb begin
    inc_amt = '0;
    dec_amt = '0;
    if (alloc_en && !alloc_nocharge && pool_hit(int'(alloc_pool), POOL_ID))
      inc_amt = W'(alloc_cost);
    if (free_en && !free_nocharge && pool_hit(int'(free_pool), POOL_ID))
      dec_amt = W'(free_cost);
    upd_en = (inc_amt != '0) || (dec_amt != '0);
    grow   = W'(used_q) + inc_amt;
    diff   = grow - dec_amt;
    uf_hit = grow < dec_amt;
    if (uf_hit)              used_d = '0;
    else if (diff > MAX_CNT) used_d = MAX_CNT[CNT_W-1:0];
    else                     used_d = diff[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      used_q <= '0;
    else if (upd_en) used_q <= used_d;
  end

  assign used = used_q;

  AST_BALANCED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_amt == dec_amt) |=> $stable(used_q)); // R4
  AST_UNDERFLOW_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    uf_hit |=> (used_q == '0)); // R11
endmodule

// File: rtl/rcred_tracker.sv
module rcred_tracker #(
  parameter int NUM_POOLS = 4,
  parameter int LANES     = 4,
  parameter int CNT_W     = 8,
  parameter int COST_W    = 3,
  parameter logic [NUM_POOLS*CNT_W-1:0] POOL_CAP = {8'd4, 8'd0, 8'd6, 8'd12},
  localparam int PW    = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1,
  localparam int REQ_W = COST_W + $clog2(LANES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LANES-1:0]           q_valid,
  input  logic [LANES*PW-1:0]        q_pool,
  input  logic [LANES*COST_W-1:0]    q_cost,
  input  logic                       alloc_en,
  input  logic [PW-1:0]              alloc_pool,
  input  logic [COST_W-1:0]          alloc_cost,
  input  logic                       alloc_nocharge,
  input  logic                       free_en,
  input  logic [PW-1:0]              free_pool,
  input  logic [COST_W-1:0]          free_cost,
  input  logic                       free_nocharge,
  output logic [NUM_POOLS-1:0]       stall_mask,
  output logic                       never_fit,
  output logic [NUM_POOLS*CNT_W-1:0] used_count,
  output logic                       underflow_err
);
  localparam int SW = ((CNT_W > REQ_W) ? CNT_W : REQ_W) + 1;

  logic [NUM_POOLS*REQ_W-1:0] req;
  logic [NUM_POOLS-1:0]       uf_vec, fatal_vec;
  logic                       uf_q, uf_d, uf_en;

  rcred_demand #(.LANES(LANES), .NUM_POOLS(NUM_POOLS), .PW(PW),
                 .COST_W(COST_W), .REQ_W(REQ_W)) u_demand (
    .q_valid(q_valid), .q_pool(q_pool), .q_cost(q_cost), .req(req));

  for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
    localparam logic [CNT_W-1:0] CAP = POOL_CAP[p*CNT_W +: CNT_W];
    logic [CNT_W-1:0] used_p;
    logic [REQ_W-1:0] req_p;
    logic [SW-1:0]    total;

    rcred_pool_ctr #(.CNT_W(CNT_W), .COST_W(COST_W), .PW(PW), .POOL_ID(p)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc_en), .alloc_pool(alloc_pool), .alloc_cost(alloc_cost),
      .alloc_nocharge(alloc_nocharge),
      .free_en(free_en), .free_pool(free_pool), .free_cost(free_cost),
      .free_nocharge(free_nocharge),
      .used(used_p), .uf_hit(uf_vec[p]));

    assign req_p = req[p*REQ_W +: REQ_W];
    assign total = SW'(used_p) + SW'(req_p);
    assign stall_mask[p] = (req_p != '0) && (CAP != '0) && (total > SW'(CAP));
    assign fatal_vec[p]  = (req_p != '0) && (CAP != '0) && (SW'(req_p) > SW'(CAP));
    assign used_count[p*CNT_W +: CNT_W] = used_p;
  end

  assign never_fit = |fatal_vec;

  always_comb begin
    uf_en = |uf_vec;
    uf_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     uf_q <= 1'b0;
    else if (uf_en) uf_q <= uf_d;
  end

  assign underflow_err = uf_q;

  AST_FATAL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    never_fit |-> (stall_mask != '0)); // R9
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err); // R11
  AST_UF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_vec != '0) |=> underflow_err); // R11
endmodule

// File: tb/test_rcred_tracker.sv
`timescale 1ns/1ps
module test_rcred_tracker;
  localparam int NP = 4, LN = 4, CW = 8, KW = 3, PW = 2;
  localparam int MAXC = 255;
  int cap_m [NP] = '{12, 6, 0, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LN-1:0]    q_valid = '0;
  logic [LN*PW-1:0] q_pool = '0;
  logic [LN*KW-1:0] q_cost = '0;
  logic alloc_en = 0, alloc_nocharge = 0, free_en = 0, free_nocharge = 0;
  logic [PW-1:0] alloc_pool = '0, free_pool = '0;
  logic [KW-1:0] alloc_cost = '0, free_cost = '0;
  logic [NP-1:0] stall_mask;
  logic never_fit, underflow_err;
  logic [NP*CW-1:0] used_count;

  always #2.5 clk = ~clk;

  rcred_tracker i_rcred_tracker (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_pool(q_pool), .q_cost(q_cost),
    .alloc_en(alloc_en), .alloc_pool(alloc_pool), .alloc_cost(alloc_cost),
    .alloc_nocharge(alloc_nocharge), .free_en(free_en), .free_pool(free_pool),
    .free_cost(free_cost), .free_nocharge(free_nocharge),
    .stall_mask(stall_mask), .never_fit(never_fit), .used_count(used_count),
    .underflow_err(underflow_err));

  int used_m [NP];
  bit uf_m;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    foreach (used_m[p]) used_m[p] = 0;
    uf_m = 0;
  endtask

  // Reference: apply the strobes that were present at the last edge.
  task automatic model_step();
    for (int p = 0; p < NP; p++) begin
      int inc = 0, dec = 0, g;
      if (alloc_en && !alloc_nocharge && (p == 0 || int'(alloc_pool) == p)) inc = alloc_cost;
      if (free_en && !free_nocharge && (p == 0 || int'(free_pool) == p)) dec = free_cost;
      g = used_m[p] + inc;
      if (g < dec) begin used_m[p] = 0; uf_m = 1; end
      else used_m[p] = (g - dec > MAXC) ? MAXC : g - dec;
    end
  endtask

  task automatic check_query(string tag);
    int req [NP];
    bit fat = 0;
    for (int p = 0; p < NP; p++) begin
      req[p] = 0;
      for (int l = 0; l < LN; l++)
        if (q_valid[l] && (p == 0 || int'(q_pool[l*PW +: PW]) == p))
          req[p] += q_cost[l*KW +: KW];
    end
    for (int p = 0; p < NP; p++) begin
      bit s = (req[p] > 0) && (cap_m[p] > 0) && (used_m[p] + req[p] > cap_m[p]);
      if ((req[p] > 0) && (cap_m[p] > 0) && (req[p] > cap_m[p])) fat = 1;
      chk(tag, $sformatf("stall_mask[%0d]", p), int'(stall_mask[p]), int'(s));
    end
    chk(tag, "never_fit", int'(never_fit), int'(fat));
  endtask

  task automatic check_state(string tag);
    for (int p = 0; p < NP; p++)
      chk(tag, $sformatf("used[%0d]", p), int'(used_count[p*CW +: CW]), used_m[p]);
    chk(tag, "underflow_err", int'(underflow_err), int'(uf_m));
  endtask

  // Called just after a falling edge with inputs set.
  task automatic cycle(string tag);
    #1 check_query(tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_state(tag);
    alloc_en = 0; free_en = 0; alloc_nocharge = 0; free_nocharge = 0;
    q_valid = '0;
  endtask

  task automatic do_alloc(int pool, int cost, bit nc);
    alloc_en = 1; alloc_pool = PW'(pool); alloc_cost = KW'(cost); alloc_nocharge = nc;
  endtask
  task automatic do_free(int pool, int cost, bit nc);
    free_en = 1; free_pool = PW'(pool); free_cost = KW'(cost); free_nocharge = nc;
  endtask
  task automatic lane(int l, bit v, int pool, int cost);
    q_valid[l] = v; q_pool[l*PW +: PW] = PW'(pool); q_cost[l*KW +: KW] = KW'(cost);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check_state("R1"); #1 check_query("R1");
    @(negedge clk);
    // R2: owning pool plus global
    do_alloc(1, 2, 0); cycle("R2");
    do_alloc(0, 1, 0); cycle("R2");
    // R6 R7 R8: lane sums, invalid lane ignored, unbounded pool
    lane(0, 1, 1, 3); lane(1, 1, 3, 2); lane(2, 0, 1, 7); lane(3, 1, 2, 5);
    cycle("R6");
    lane(0, 1, 2, 5); cycle("R8");
    lane(0, 1, 2, 7); lane(1, 1, 2, 7); lane(2, 1, 2, 7); cycle("R8");
    // R3: free from both
    do_free(1, 2, 0); cycle("R3");
    // R4: nocharge
    do_alloc(3, 4, 1); cycle("R4");
    do_alloc(3, 3, 0); cycle("R2");
    do_free(3, 3, 1); cycle("R4");
    // R5: simultaneous net
    do_alloc(1, 4, 0); do_free(3, 2, 0); cycle("R5");
    do_alloc(3, 2, 0); do_free(3, 2, 0); cycle("R5");
    // R7: threshold on pool 3 (used 1, cap 4)
    lane(0, 1, 3, 3); cycle("R7");
    lane(0, 1, 3, 3); lane(1, 1, 3, 1); cycle("R7");
    // R9: single group larger than a bounded pool
    lane(0, 1, 3, 3); lane(1, 1, 3, 2); cycle("R9");
    lane(0, 1, 1, 7); cycle("R9");
    // R11: underflow clamps, sticky
    do_free(1, 7, 0); cycle("R11");
    cycle("R11"); cycle("R11");
    do_reset(); check_state("R1");
    // R10: saturation
    for (int i = 0; i < 40; i++) begin do_alloc(2, 7, 0); cycle("R10"); end
    do_alloc(2, 7, 0); do_free(2, 1, 0); cycle("R10");
    do_free(2, 7, 0); cycle("R10");
    do_reset(); check_state("R1");
    // Random traffic: R5 R6 R7 mixed
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 1)) do_alloc($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3) == 0);
      if ($urandom_range(0, 2) == 0) do_free($urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(0, 3) == 0);
      for (int l = 0; l < LN; l++) lane(l, $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 4));
      cycle("R5");
    end
    finish_run();
  end
endmodule